// File: doc/BRIEF.md
# Execute Packet Cross-Path Checker

This block judges one execute packet of a two-sided VLIW datapath against the rules for moving operands between the two register-file sides. Each side has an L, S, M and D unit and a 16-entry file of 32-bit registers. Up to eight instruction descriptors arrive in parallel, one per slot, as flat vectors. Each descriptor gives:

- the target unit and the side it sits on;
- the destination side and the sides of both sources;
- a declared cross-path flag;
- an optional condition register with an invert bit.

On a strobe the block captures one verdict. It raises one violation bit per broken rule and an overall pass bit, and holds both until the next strobe.

For an L, S or M slot, `dst_side` is the destination register side and the two source sides name the operand files. For a D slot, `srca_side` is the side of the pointer register and `dst_side` is the side of the data being loaded or stored. `srcb_side` is not used for a D slot. An instruction decoder or packet builder uses the verdict to reject or split an illegal packet before it issues.

Top module: `xpc_packet_checker`

## Requirements
- R1: While reset is asserted and after it, until the first strobe: `packet_ok` is 1, `rule_viol` is 0 and `verdict_valid` is 0.
- R2: A strobe sampled at a clock edge updates `rule_viol` and `packet_ok` at that same edge and raises `verdict_valid` for exactly that one cycle. Without a strobe, changes on any descriptor input leave `rule_viol` and `packet_ok` unchanged.
- R3: `packet_ok` is 1 exactly when every bit of `rule_viol` is 0. Several violation bits may be set together.
- R4: `rule_viol[0]` is set when two used slots name the same unit kind on the same side. Unit kind codes are 0=L, 1=S, 2=M, 3=D, and side 0 is A, side 1 is B. The same kind on opposite sides is legal.
- R5: `rule_viol[1]` is set when a used L, S or M slot has a destination side different from its unit side. A D slot may move data to or from either side without setting this bit.
- R6: `rule_viol[2]` is set when the cross-path flag of a used L, S or M slot does not match its operands. This covers three cases:
  - the flag is set but neither source is on the opposite side;
  - the flag is clear but a source is on the opposite side;
  - both sources are on the opposite side.
- R7: `rule_viol[3]` is set when more than one used L, S or M slot on the same side sets its cross-path flag. One crossing on each side in the same packet is legal.
- R8: `rule_viol[4]` is set when a used D slot sets the data cross-path flag.
- R9: `rule_viol[5]` is set when a used D slot has its pointer register on the side opposite the unit.
- R10: `rule_viol[6]` is set when the used D slots disagree about crossing, that is, at least one moves data across sides (data side differs from unit side) and at least one does not.
- R11: `rule_viol[7]` is set for a used slot whose condition is enabled on a register other than A1, A2, B0, B1 or B2. It is also set for a used slot that has the invert bit set with no condition enabled. Inverting a legal condition has no effect. A condition read from the opposite side does not count as cross-path use.
- R12: Slots with `slot_used` at 0 contribute to no rule, whatever their other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_strobe | input | 1 | Capture a verdict for the packet presented now |
| slot_used | input | SLOTS | Slot i holds an instruction (bit i) |
| slot_unit | input | 2*SLOTS | Unit kind of slot i at bits [2i+1:2i] |
| slot_side | input | SLOTS | Side of the unit of slot i |
| slot_dst_side | input | SLOTS | Destination side (L/S/M) or data side (D) |
| slot_srca_side | input | SLOTS | First source side (L/S/M) or pointer side (D) |
| slot_srcb_side | input | SLOTS | Second source side (L/S/M only) |
| slot_xflag | input | SLOTS | Declared data cross-path use |
| slot_cond_en | input | SLOTS | Instruction is conditional |
| slot_cond_side | input | SLOTS | Side of the condition register |
| slot_cond_reg | input | 4*SLOTS | Condition register index of slot i at bits [4i+3:4i] |
| slot_cond_inv | input | SLOTS | Execute when the condition register is zero |
| verdict_valid | output | 1 | One-cycle pulse following a captured strobe |
| packet_ok | output | 1 | Captured packet broke no rule |
| rule_viol | output | 8 | Per-rule violation bits of the captured packet |

## Verification
Every result of this block is due one clock edge after the strobe: the edge that samples `pkt_strobe` high also loads `rule_viol` and `packet_ok` and raises `verdict_valid`. The bench drives descriptors and the strobe on falling edges and reads the outputs at the falling edge that follows the capturing rising edge, so each check lands half a cycle after the update. The bench checks that the pulse is gone one cycle later. In the hold scenario it alters every descriptor field with the strobe low for several cycles and confirms that the verdict has not moved.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

  typedef enum logic [1:0] {
    UK_L = 2'd0,
    UK_S = 2'd1,
    UK_M = 2'd2,
    UK_D = 2'd3
  } unit_kind_e;

  localparam int KIND_W      = 2;
  localparam int UNIT_CODE_W = KIND_W + 1;
  localparam int NUM_CODES   = 1 << UNIT_CODE_W;

  localparam int RULE_DUP   = 0;
  localparam int RULE_DST   = 1;
  localparam int RULE_XDECL = 2;
  localparam int RULE_BUSY  = 3;
  localparam int RULE_DXP   = 4;
  localparam int RULE_PTR   = 5;
  localparam int RULE_MIX   = 6;
  localparam int RULE_COND  = 7;
  localparam int RULE_W     = 8;

endpackage

// File: rtl/xpc_slot_rules.sv
module xpc_slot_rules #(
  parameter int REG_IDX_W = 4
) (
  input  logic                               used,
  input  logic [xpc_pkg::KIND_W-1:0]         kind,
  input  logic                               side,
  input  logic                               dst_side,
  input  logic                               srca_side,
  input  logic                               srcb_side,
  input  logic                               xflag,
  input  logic                               cond_en,
  input  logic                               cond_side,
  input  logic [REG_IDX_W-1:0]               cond_reg,
  input  logic                               cond_inv,
  output logic                               dst_bad,
  output logic                               xdecl_bad,
  output logic                               dxp_bad,
  output logic                               ptr_bad,
  output logic                               cond_bad,
  output logic                               xuse_a,
  output logic                               xuse_b,
  output logic                               d_used,
  output logic                               d_cross,
  output logic [xpc_pkg::UNIT_CODE_W-1:0]    unit_code
);
  import xpc_pkg::*;

  localparam logic [REG_IDX_W-1:0] REG_ZERO = '0;
  localparam logic [REG_IDX_W-1:0] REG_ONE  = REG_IDX_W'(1);
  localparam logic [REG_IDX_W-1:0] REG_TWO  = REG_IDX_W'(2);

  logic       is_d;
  logic [1:0] opp_cnt;
  logic       cond_legal;
  logic       alu_used;

  always_comb begin
    is_d     = (kind == UK_D);
    alu_used = used && !is_d;
    opp_cnt  = {1'b0, srca_side != side} + {1'b0, srcb_side != side};

    // side A offers registers 1 and 2, side B offers 0, 1 and 2
    if (cond_side == 1'b0) begin
      cond_legal = (cond_reg == REG_ONE) || (cond_reg == REG_TWO);
    end else begin
      cond_legal = (cond_reg == REG_ZERO) || (cond_reg == REG_ONE) ||
                   (cond_reg == REG_TWO);
    end

    dst_bad   = alu_used && (dst_side != side);
    xdecl_bad = alu_used && ((opp_cnt == 2'd2) ||
                             (xflag && (opp_cnt == 2'd0)) ||
                             (!xflag && (opp_cnt != 2'd0)));
    dxp_bad   = used && is_d && xflag;
    ptr_bad   = used && is_d && (srca_side != side);
    cond_bad  = used && (cond_en ? !cond_legal : cond_inv);

    xuse_a    = alu_used && xflag && (side == 1'b0);
    xuse_b    = alu_used && xflag && (side == 1'b1);
    d_used    = used && is_d;
    d_cross   = used && is_d && (dst_side != side);
    unit_code = {side, kind};
  end

endmodule

// File: rtl/xpc_packet_rules.sv
module xpc_packet_rules #(
  parameter int SLOTS = 8
) (
  input  logic [SLOTS-1:0]                              used,
  input  logic [SLOTS*xpc_pkg::UNIT_CODE_W-1:0]         unit_codes,
  input  logic [SLOTS-1:0]                              xuse_a,
  input  logic [SLOTS-1:0]                              xuse_b,
  input  logic [SLOTS-1:0]                              d_used,
  input  logic [SLOTS-1:0]                              d_cross,
  output logic                                          dup_bad,
  output logic                                          busy_bad,
  output logic                                          mix_bad
);
  import xpc_pkg::*;

  logic [NUM_CODES-1:0][SLOTS-1:0] code_hit;
  logic [NUM_CODES-1:0]            code_dup;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign code_hit[c][s] = used[s] &&
        (unit_codes[s*UNIT_CODE_W +: UNIT_CODE_W] == UNIT_CODE_W'(c));
    end
    assign code_dup[c] = ($countones(code_hit[c]) > 1);
  end

  always_comb begin
    dup_bad  = |code_dup;
    busy_bad = ($countones(xuse_a) > 1) || ($countones(xuse_b) > 1);
    mix_bad  = (|d_cross) && (|(d_used & ~d_cross));
  end

endmodule

// File: rtl/xpc_packet_checker.sv
module xpc_packet_checker #(
  parameter int SLOTS     = 8,
  parameter int REG_IDX_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pkt_strobe,
  input  logic [SLOTS-1:0]              slot_used,
  input  logic [2*SLOTS-1:0]            slot_unit,
  input  logic [SLOTS-1:0]              slot_side,
  input  logic [SLOTS-1:0]              slot_dst_side,
  input  logic [SLOTS-1:0]              slot_srca_side,
  input  logic [SLOTS-1:0]              slot_srcb_side,
  input  logic [SLOTS-1:0]              slot_xflag,
  input  logic [SLOTS-1:0]              slot_cond_en,
  input  logic [SLOTS-1:0]              slot_cond_side,
  input  logic [REG_IDX_W*SLOTS-1:0]    slot_cond_reg,
  input  logic [SLOTS-1:0]              slot_cond_inv,
  output logic                          verdict_valid,
  output logic                          packet_ok,
  output logic [xpc_pkg::RULE_W-1:0]    rule_viol
);
  import xpc_pkg::*;

  logic [SLOTS-1:0]             dst_bad, xdecl_bad, dxp_bad, ptr_bad, cond_bad;
  logic [SLOTS-1:0]             xuse_a, xuse_b, d_used, d_cross;
  logic [SLOTS*UNIT_CODE_W-1:0] unit_codes;
  logic                         dup_bad, busy_bad, mix_bad;

  logic [RULE_W-1:0]            viol_d;
  logic                         ok_d;
  logic                         valid_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    xpc_slot_rules #(.REG_IDX_W(REG_IDX_W)) u_slot (
      .used      (slot_used[g]),
      .kind      (slot_unit[g*KIND_W +: KIND_W]),
      .side      (slot_side[g]),
      .dst_side  (slot_dst_side[g]),
      .srca_side (slot_srca_side[g]),
      .srcb_side (slot_srcb_side[g]),
      .xflag     (slot_xflag[g]),
      .cond_en   (slot_cond_en[g]),
      .cond_side (slot_cond_side[g]),
      .cond_reg  (slot_cond_reg[g*REG_IDX_W +: REG_IDX_W]),
      .cond_inv  (slot_cond_inv[g]),
      .dst_bad   (dst_bad[g]),
      .xdecl_bad (xdecl_bad[g]),
      .dxp_bad   (dxp_bad[g]),
      .ptr_bad   (ptr_bad[g]),
      .cond_bad  (cond_bad[g]),
      .xuse_a    (xuse_a[g]),
      .xuse_b    (xuse_b[g]),
      .d_used    (d_used[g]),
      .d_cross   (d_cross[g]),
      .unit_code (unit_codes[g*UNIT_CODE_W +: UNIT_CODE_W])
    );
  end

  xpc_packet_rules #(.SLOTS(SLOTS)) u_packet (
    .used       (slot_used),
    .unit_codes (unit_codes),
    .xuse_a     (xuse_a),
    .xuse_b     (xuse_b),
    .d_used     (d_used),
    .d_cross    (d_cross),
    .dup_bad    (dup_bad),
    .busy_bad   (busy_bad),
    .mix_bad    (mix_bad)
  );

  // next-state
  always_comb begin
    viol_d             = '0;
    viol_d[RULE_DUP]   = dup_bad;
    viol_d[RULE_DST]   = |dst_bad;
    viol_d[RULE_XDECL] = |xdecl_bad;
    viol_d[RULE_BUSY]  = busy_bad;
    viol_d[RULE_DXP]   = |dxp_bad;
    viol_d[RULE_PTR]   = |ptr_bad;
    viol_d[RULE_MIX]   = mix_bad;
    viol_d[RULE_COND]  = |cond_bad;
    ok_d               = ~|viol_d;
    valid_d            = pkt_strobe;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      packet_ok     <= 1'b1;
      rule_viol     <= '0;
    end else begin
      verdict_valid <= valid_d;
      if (pkt_strobe) begin
        packet_ok <= ok_d;
        rule_viol <= viol_d;
      end
    end
  end

endmodule

// File: rtl/xpc_packet_checker_sva.sv
module xpc_packet_checker_sva #(
  parameter int SLOTS     = 8,
  parameter int REG_IDX_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          pkt_strobe,
  input logic [SLOTS-1:0]              slot_used,
  input logic [2*SLOTS-1:0]            slot_unit,
  input logic [SLOTS-1:0]              slot_side,
  input logic [SLOTS-1:0]              slot_dst_side,
  input logic [SLOTS-1:0]              slot_srca_side,
  input logic [SLOTS-1:0]              slot_cond_en,
  input logic [SLOTS-1:0]              slot_cond_side,
  input logic [REG_IDX_W*SLOTS-1:0]    slot_cond_reg,
  input logic                          verdict_valid,
  input logic                          packet_ok,
  input logic [xpc_pkg::RULE_W-1:0]    rule_viol
);
  import xpc_pkg::*;

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_strobe |=> verdict_valid);

  // R2
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_strobe |=> !verdict_valid);

  // R2
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_strobe |=> ($stable(rule_viol) && $stable(packet_ok)));

  // R3
  ok_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (packet_ok == (rule_viol == '0)));

  // R5
  dst_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_strobe && slot_used[0] && (slot_unit[1:0] != 2'd3) &&
     (slot_dst_side[0] != slot_side[0])) |=> rule_viol[RULE_DST]);

  // R9
  ptr_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_strobe && slot_used[0] && (slot_unit[1:0] == 2'd3) &&
     (slot_srca_side[0] != slot_side[0])) |=> rule_viol[RULE_PTR]);

  // R11
  cond_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_strobe && slot_used[0] && slot_cond_en[0] && !slot_cond_side[0] &&
     (slot_cond_reg[REG_IDX_W-1:0] == '0)) |=> rule_viol[RULE_COND]);

endmodule

bind xpc_packet_checker xpc_packet_checker_sva #(
  .SLOTS(SLOTS), .REG_IDX_W(REG_IDX_W)
) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .pkt_strobe     (pkt_strobe),
  .slot_used      (slot_used),
  .slot_unit      (slot_unit),
  .slot_side      (slot_side),
  .slot_dst_side  (slot_dst_side),
  .slot_srca_side (slot_srca_side),
  .slot_cond_en   (slot_cond_en),
  .slot_cond_side (slot_cond_side),
  .slot_cond_reg  (slot_cond_reg),
  .verdict_valid  (verdict_valid),
  .packet_ok      (packet_ok),
  .rule_viol      (rule_viol)
);

// File: tb/xpc_packet_checker_bench.sv
`timescale 1ns/1ps
module xpc_packet_checker_bench;
  localparam int S  = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_strobe;
  logic [S-1:0]  slot_used, slot_side, slot_dst_side, slot_srca_side;
  logic [S-1:0]  slot_srcb_side, slot_xflag, slot_cond_en, slot_cond_side;
  logic [S-1:0]  slot_cond_inv;
  logic [2*S-1:0]  slot_unit;
  logic [RW*S-1:0] slot_cond_reg;
  logic          verdict_valid, packet_ok;
  logic [7:0]    rule_viol;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xpc_packet_checker #(.SLOTS(S), .REG_IDX_W(RW)) u_xpc_packet_checker (
    .clk(clk), .rst_n(rst_n), .pkt_strobe(pkt_strobe),
    .slot_used(slot_used), .slot_unit(slot_unit), .slot_side(slot_side),
    .slot_dst_side(slot_dst_side), .slot_srca_side(slot_srca_side),
    .slot_srcb_side(slot_srcb_side), .slot_xflag(slot_xflag),
    .slot_cond_en(slot_cond_en), .slot_cond_side(slot_cond_side),
    .slot_cond_reg(slot_cond_reg), .slot_cond_inv(slot_cond_inv),
    .verdict_valid(verdict_valid), .packet_ok(packet_ok), .rule_viol(rule_viol)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_pkt();
    slot_used = '0; slot_unit = '0; slot_side = '0; slot_dst_side = '0;
    slot_srca_side = '0; slot_srcb_side = '0; slot_xflag = '0;
    slot_cond_en = '0; slot_cond_side = '0; slot_cond_reg = '0;
    slot_cond_inv = '0;
  endtask

  // kind 0=L 1=S 2=M 3=D ; side 0=A 1=B
  task automatic put(int i, int kind, bit side, bit dst, bit sa, bit sb, bit x);
    slot_used[i] = 1'b1;
    slot_unit[2*i +: 2] = 2'(kind);
    slot_side[i] = side; slot_dst_side[i] = dst;
    slot_srca_side[i] = sa; slot_srcb_side[i] = sb; slot_xflag[i] = x;
  endtask

  task automatic put_cond(int i, bit en, bit side, int rg, bit inv);
    slot_cond_en[i] = en; slot_cond_side[i] = side;
    slot_cond_reg[RW*i +: RW] = RW'(rg); slot_cond_inv[i] = inv;
  endtask

  task automatic send();
    @(negedge clk); pkt_strobe = 1'b1;
    @(negedge clk); pkt_strobe = 1'b0;
  endtask

  task automatic expect_verdict(string req, logic [7:0] exp);
    check({req, " valid"}, 32'(verdict_valid), 32'd1);
    check({req, " viol"}, 32'(rule_viol), 32'(exp));
    check({req, " ok"}, 32'(packet_ok), 32'(exp == 8'h00));
  endtask

  task automatic t_reset();
    check("R1 ok", 32'(packet_ok), 32'd1);
    check("R1 viol", 32'(rule_viol), 32'd0);
    check("R1 valid", 32'(verdict_valid), 32'd0);
  endtask

  task automatic t_full_legal();
    clear_pkt();
    for (int k = 0; k < 8; k++) put(k, k % 4, bit'(k / 4), bit'(k / 4), bit'(k / 4), bit'(k / 4), 0);
    send();
    expect_verdict("R3 R4 full legal", 8'h00);
    @(negedge clk);
    check("R2 pulse ends", 32'(verdict_valid), 32'd0);
  endtask

  task automatic t_dup();
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put(1, 0, 0, 0, 0, 0, 0);
    send(); expect_verdict("R4 two L on A", 8'h01);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put(1, 0, 1, 1, 1, 1, 0);
    send(); expect_verdict("R4 L on each side", 8'h00);
  endtask

  task automatic t_dst();
    clear_pkt(); put(0, 2, 0, 1, 0, 0, 0);
    send(); expect_verdict("R5 M dst opposite", 8'h02);
    clear_pkt(); put(0, 3, 0, 1, 0, 0, 0);
    send(); expect_verdict("R5 D data opposite", 8'h00);
  endtask

  task automatic t_xdecl();
    clear_pkt(); put(0, 0, 0, 0, 1, 0, 0);
    send(); expect_verdict("R6 undeclared cross", 8'h04);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 1);
    send(); expect_verdict("R6 flag without cross", 8'h04);
    clear_pkt(); put(0, 1, 0, 0, 1, 1, 1);
    send(); expect_verdict("R6 two crossed sources", 8'h04);
    clear_pkt(); put(0, 1, 0, 0, 1, 0, 1);
    send(); expect_verdict("R6 proper cross", 8'h00);
  endtask

  task automatic t_busy();
    clear_pkt(); put(0, 0, 0, 0, 1, 0, 1); put(1, 1, 0, 0, 0, 1, 1);
    send(); expect_verdict("R7 two crossings side A", 8'h08);
    clear_pkt(); put(0, 0, 0, 0, 1, 0, 1); put(1, 1, 1, 1, 0, 1, 1);
    send(); expect_verdict("R7 one crossing per side", 8'h00);
  endtask

  task automatic t_dxp();
    clear_pkt(); put(0, 3, 0, 0, 0, 0, 1);
    send(); expect_verdict("R8 D with data cross", 8'h10);
  endtask

  task automatic t_ptr();
    clear_pkt(); put(0, 3, 1, 1, 0, 1, 0);
    send(); expect_verdict("R9 pointer opposite", 8'h20);
  endtask

  task automatic t_mix();
    clear_pkt(); put(0, 3, 0, 1, 0, 0, 0); put(1, 3, 1, 1, 1, 1, 0);
    send(); expect_verdict("R10 one crosses", 8'h40);
    clear_pkt(); put(0, 3, 0, 1, 0, 0, 0); put(1, 3, 1, 0, 1, 1, 0);
    send(); expect_verdict("R10 both cross", 8'h00);
  endtask

  task automatic t_cond();
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put_cond(0, 1, 0, 0, 0);
    send(); expect_verdict("R11 A0 condition", 8'h80);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put_cond(0, 1, 1, 2, 1);
    send(); expect_verdict("R11 B2 inverted", 8'h00);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put_cond(0, 1, 0, 3, 0);
    send(); expect_verdict("R11 A3 condition", 8'h80);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0); put_cond(0, 0, 0, 0, 1);
    send(); expect_verdict("R11 invert without cond", 8'h80);
    clear_pkt();
    put(0, 0, 0, 0, 1, 0, 1); put_cond(0, 1, 1, 1, 0);
    put(1, 1, 0, 0, 0, 0, 0); put_cond(1, 1, 1, 0, 1);
    send(); expect_verdict("R11 opposite cond no cross", 8'h00);
  endtask

  task automatic t_unused();
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0);
    put(3, 0, 0, 1, 1, 1, 0); put_cond(3, 1, 0, 0, 1);
    put(5, 3, 0, 1, 1, 0, 1);
    slot_used[3] = 1'b0; slot_used[5] = 1'b0;
    send(); expect_verdict("R12 unused slots ignored", 8'h00);
  endtask

  task automatic t_multi();
    clear_pkt(); put(0, 2, 1, 1, 1, 1, 0); put(1, 2, 1, 1, 1, 1, 0);
    put_cond(1, 1, 0, 0, 0);
    send(); expect_verdict("R3 dup plus cond", 8'h81);
  endtask

  task automatic t_hold();
    clear_pkt(); put(0, 1, 1, 0, 1, 1, 0);
    send(); expect_verdict("R2 setup", 8'h02);
    clear_pkt(); put(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R2 hold viol", 32'(rule_viol), 32'h02);
    check("R2 hold ok", 32'(packet_ok), 32'd0);
    check("R2 hold valid", 32'(verdict_valid), 32'd0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; pkt_strobe = 1'b0; clear_pkt();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_legal();
    t_dup();
    t_dst();
    t_xdecl();
    t_busy();
    t_dxp();
    t_ptr();
    t_mix();
    t_cond();
    t_unused();
    t_multi();
    t_hold();
    finish_run();
  end

endmodule